// File: doc/BRIEF.md
# Multi-Source Bridge Reset Sequencer

This block turns five reset causes into the internal reset domains of a bridge between a serial link and a parallel bus. The five causes are a supply monitor, an asynchronous global pin, an upstream link-reset pin, an in-band hot-reset level and a software bit for the secondary bus. Each cause clears a different share of the bridge state. The block therefore drives a separate active-high reset for each class of state: power-management logic, sticky bits, EEPROM-loadable bits and ordinary (non-sticky) bits. It also drives the reset for the secondary parallel bus.

Power-on release happens in three steps. The block first waits for the supply-good flag. It then waits for the reference-clock activity flag. Last, it counts a fixed delay (10 µs at the nominal clock). Pin resets assert at once with no clock and are released through a two-flop synchroniser. When several causes are active, the widest scope wins. The scope narrows only as each cause goes away.

Whenever a link-or-wider reset releases, the block pulses three things. It gives a strap-latch strobe. It gives an EEPROM download start, but only if an EEPROM is present. It starts the timer that enables link training, well inside the 80 ms allowance.

Top module: `bridge_rst_seq`

## Requirements
- R1: While `pwr_good` is low, all four class resets and `sec_bus_rst` are high and `link_train_en` is low. The class vector {pm, sticky, eeload, nonsticky} reads 4'b1111.
- R2: After `pwr_good` has been high for the synchroniser delay, the full reset holds while `refclk_active` is low. It releases on the (POR_DLY_CYC+1)-th rising edge after `refclk_active` is first sampled high, provided both pins are high.
- R3: `glob_rst_n` low drives the class vector to 4'b1111 and `sec_bus_rst` high at once, before any clock edge.
- R4: After `glob_rst_n` returns high, the resets stay asserted through the first rising edge and drop on the second.
- R5: `link_rst_n` low gives class vector 4'b0011 (eeload and nonsticky only), sets `sec_bus_rst` and clears `link_train_en`.
- R6: `hot_rst` high gives class vector 4'b0001 and sets `sec_bus_rst`.
- R7: With several causes active, the widest scope applies (full > link > hot). As each cause releases, the output falls to the scope of the widest cause still active.
- R8: `sw_sec_rst` drives `sec_bus_rst` while it is 1 and leaves every class reset unchanged. Writing 0 releases the secondary bus reset.
- R9: `strap_latch` is high for exactly one cycle each time the scope falls from link-or-wider to hot or none. A hot-reset release alone gives no strobe.
- R10: `eeprom_dl_start` pulses in the same cycle as `strap_latch` when `eeprom_present` is 1, and stays low when it is 0.
- R11: `link_train_en` is low while a link-or-wider reset is active. It rises TRAIN_DLY_CYC rising edges after the edge that released that reset. It stays high through a hot reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running core clock |
| pwr_good | input | 1 | Supply at or above 90% of nominal; low asynchronously restarts power-on |
| refclk_active | input | 1 | Reference clock activity detected |
| glob_rst_n | input | 1 | Global reset pin, active low, asynchronous |
| link_rst_n | input | 1 | Upstream link reset pin, active low, asynchronous |
| hot_rst | input | 1 | In-band hot reset / data-link-down level, synchronous |
| sw_sec_rst | input | 1 | Software secondary-bus reset control bit |
| eeprom_present | input | 1 | Serial EEPROM detected |
| rst_pm | output | 1 | Reset for power-management logic |
| rst_sticky | output | 1 | Reset for sticky register bits |
| rst_eeload | output | 1 | Reset for EEPROM-loadable bits |
| rst_nonsticky | output | 1 | Reset for ordinary bits and state machines |
| sec_bus_rst | output | 1 | Secondary parallel bus reset |
| strap_latch | output | 1 | One-cycle strobe to latch static straps |
| eeprom_dl_start | output | 1 | One-cycle EEPROM download start |
| link_train_en | output | 1 | Link training enable |

## Verification
The bench applies each reset cause on its own and checks the resulting class vector. This separates the full, link and hot scopes and shows the software bit acting on the secondary bus alone. A stacked pattern applies hot, then link, then global, and releases them widest first. That pattern shows whether scope narrows in steps or falls straight to none. The power-on pattern holds the clock-activity flag low, then raises it and counts edges, which tells a missing clock wait apart from a wrong delay length. Pin releases are sampled one edge early and on time to show the two-flop release. Pulse counts around each release, with and without an EEPROM, tell the release strobes apart from a hot-reset exit.

// File: rtl/brs_pkg.sv
package brs_pkg;

    typedef enum logic [1:0] {
        SCOPE_NONE = 2'd0,
        SCOPE_HOT  = 2'd1,
        SCOPE_LINK = 2'd2,
        SCOPE_FULL = 2'd3
    } rst_scope_e;

    typedef enum logic [1:0] {
        POR_PWR,
        POR_CLK,
        POR_DLY,
        POR_DONE
    } por_state_e;

    typedef struct packed {
        logic pm;
        logic sticky;
        logic eeload;
        logic nonsticky;
    } rst_class_t;

    localparam int unsigned SYNC_STAGES = 2;

    function automatic rst_scope_e scope_widest(rst_scope_e a, rst_scope_e b);
        return (a > b) ? a : b;
    endfunction

    function automatic rst_class_t scope_decode(rst_scope_e s);
        rst_class_t c;
        c.pm        = (s == SCOPE_FULL);
        c.sticky    = (s == SCOPE_FULL);
        c.eeload    = (s >= SCOPE_LINK);
        c.nonsticky = (s >= SCOPE_HOT);
        return c;
    endfunction

endpackage

// File: rtl/brs_rst_sync.sv
module brs_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic released
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign released = chain_q[STAGES-1];
endmodule

// File: rtl/brs_por_seq.sv
module brs_por_seq
    import brs_pkg::*;
#(
    parameter int unsigned DLY_CYCLES = 1250
) (
    input  logic clk,
    input  logic pwr_good,
    input  logic refclk_active,
    output logic por_active
);
    localparam int unsigned CW = (DLY_CYCLES > 1) ? $clog2(DLY_CYCLES) : 1;

    por_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          pg_synced;

    brs_rst_sync #(.STAGES(SYNC_STAGES)) u_pg_sync (
        .clk      (clk),
        .arst_n   (pwr_good),
        .released (pg_synced)
    );

    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            state_q <= POR_PWR;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                POR_PWR: if (pg_synced) state_q <= POR_CLK;
                POR_CLK: if (refclk_active) begin
                    state_q <= POR_DLY;
                    cnt_q   <= '0;
                end
                POR_DLY: begin
                    if (!refclk_active)                    state_q <= POR_CLK;
                    else if (cnt_q == CW'(DLY_CYCLES - 1)) state_q <= POR_DONE;
                    else                                   cnt_q   <= cnt_q + 1'b1;
                end
                default: state_q <= POR_DONE;
            endcase
        end
    end

    assign por_active = (state_q != POR_DONE);

    // R1
    pwr_low_chk: assert property (@(posedge clk) !pwr_good |-> por_active);

    // R2
    por_release_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        $fell(por_active) |-> $past(refclk_active));
endmodule

// File: rtl/brs_train_timer.sv
module brs_train_timer #(
    parameter int unsigned DLY_CYCLES = 2500000
) (
    input  logic clk,
    input  logic pwr_good,
    input  logic hold,
    output logic train_en
);
    localparam int unsigned CW = (DLY_CYCLES > 1) ? $clog2(DLY_CYCLES) : 1;

    logic [CW-1:0] cnt_q;
    logic          en_q;

    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
        end else if (hold) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
        end else if (!en_q) begin
            if (cnt_q == CW'(DLY_CYCLES - 1)) en_q  <= 1'b1;
            else                              cnt_q <= cnt_q + 1'b1;
        end
    end

    assign train_en = en_q && !hold;

    // R11
    train_keep_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        (en_q && !hold) |=> en_q);
endmodule

// File: rtl/bridge_rst_seq.sv
module bridge_rst_seq
    import brs_pkg::*;
#(
    parameter int unsigned CLK_HZ        = 125_000_000,
    parameter int unsigned POR_DLY_CYC   = CLK_HZ / 100_000,
    parameter int unsigned TRAIN_DLY_CYC = (CLK_HZ / 1000) * 20
) (
    input  logic clk,
    input  logic pwr_good,
    input  logic refclk_active,
    input  logic glob_rst_n,
    input  logic link_rst_n,
    input  logic hot_rst,
    input  logic sw_sec_rst,
    input  logic eeprom_present,
    output logic rst_pm,
    output logic rst_sticky,
    output logic rst_eeload,
    output logic rst_nonsticky,
    output logic sec_bus_rst,
    output logic strap_latch,
    output logic eeprom_dl_start,
    output logic link_train_en
);
    localparam int unsigned NPINS = 2;
    localparam int unsigned PIN_GLOB = 0;
    localparam int unsigned PIN_LINK = 1;

    logic [NPINS-1:0] pin_n;
    logic [NPINS-1:0] pin_rel;
    logic             por_active;
    rst_scope_e       scope;
    rst_class_t       cls;
    logic             wide_now;
    logic             wide_prev_q;
    logic             release_evt;

    assign pin_n[PIN_GLOB] = glob_rst_n;
    assign pin_n[PIN_LINK] = link_rst_n;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin_sync
        brs_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .arst_n   (pin_n[i]),
            .released (pin_rel[i])
        );
    end

    brs_por_seq #(.DLY_CYCLES(POR_DLY_CYC)) u_por (
        .clk           (clk),
        .pwr_good      (pwr_good),
        .refclk_active (refclk_active),
        .por_active    (por_active)
    );

    always_comb begin
        scope = SCOPE_NONE;
        if (hot_rst)                       scope = scope_widest(scope, SCOPE_HOT);
        if (!pin_rel[PIN_LINK])            scope = scope_widest(scope, SCOPE_LINK);
        if (por_active || !pin_rel[PIN_GLOB]) scope = scope_widest(scope, SCOPE_FULL);
    end

    assign cls           = scope_decode(scope);
    assign rst_pm        = cls.pm;
    assign rst_sticky    = cls.sticky;
    assign rst_eeload    = cls.eeload;
    assign rst_nonsticky = cls.nonsticky;
    assign sec_bus_rst   = (scope != SCOPE_NONE) || sw_sec_rst;

    assign wide_now = (scope >= SCOPE_LINK);

    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) wide_prev_q <= 1'b1;
        else           wide_prev_q <= wide_now;
    end

    assign release_evt     = wide_prev_q && !wide_now;
    assign strap_latch     = release_evt;
    assign eeprom_dl_start = release_evt && eeprom_present;

    brs_train_timer #(.DLY_CYCLES(TRAIN_DLY_CYC)) u_train (
        .clk      (clk),
        .pwr_good (pwr_good),
        .hold     (wide_now),
        .train_en (link_train_en)
    );

    // R3
    glob_full_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        !glob_rst_n |-> (rst_pm && rst_sticky && rst_eeload && rst_nonsticky && sec_bus_rst));

    // R5
    link_scope_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        !link_rst_n |-> (rst_eeload && rst_nonsticky && !link_train_en));

    // R6
    hot_scope_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        hot_rst |-> (rst_nonsticky && sec_bus_rst));

    // R9
    strap_pulse_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        strap_latch |=> !strap_latch);
endmodule

// File: tb/test_bridge_rst_seq.sv
`timescale 1ns/1ps
module test_bridge_rst_seq;
    localparam int unsigned POR_DLY   = 10;
    localparam int unsigned TRAIN_DLY = 16;

    logic clk = 1'b0;
    logic pwr_good = 1'b0, refclk_active = 1'b0;
    logic glob_rst_n = 1'b1, link_rst_n = 1'b1, hot_rst = 1'b0;
    logic sw_sec_rst = 1'b0, eeprom_present = 1'b0;
    logic rst_pm, rst_sticky, rst_eeload, rst_nonsticky;
    logic sec_bus_rst, strap_latch, eeprom_dl_start, link_train_en;

    int checks = 0;
    int errors = 0;
    int strap_cnt = 0;
    int ee_cnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bridge_rst_seq #(
        .CLK_HZ(125_000_000), .POR_DLY_CYC(POR_DLY), .TRAIN_DLY_CYC(TRAIN_DLY)
    ) i_bridge_rst_seq (
        .clk(clk), .pwr_good(pwr_good), .refclk_active(refclk_active),
        .glob_rst_n(glob_rst_n), .link_rst_n(link_rst_n), .hot_rst(hot_rst),
        .sw_sec_rst(sw_sec_rst), .eeprom_present(eeprom_present),
        .rst_pm(rst_pm), .rst_sticky(rst_sticky), .rst_eeload(rst_eeload),
        .rst_nonsticky(rst_nonsticky), .sec_bus_rst(sec_bus_rst),
        .strap_latch(strap_latch), .eeprom_dl_start(eeprom_dl_start),
        .link_train_en(link_train_en)
    );

    always @(negedge clk) begin
        if (strap_latch)     strap_cnt++;
        if (eeprom_dl_start) ee_cnt++;
    end

    function automatic logic [3:0] cls();
        return {rst_pm, rst_sticky, rst_eeload, rst_nonsticky};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic edges_until_train(input string req);
        int k = 0;
        while (!link_train_en && k < 1000) begin
            @(posedge clk); #1; k++;
        end
        chk(req, k, TRAIN_DLY);
    endtask

    task automatic t_power_on();
        int n = 0;
        int s0;
        cycles(3);
        chk("R1 class", cls(), 4'b1111);
        chk("R1 sec", sec_bus_rst, 1);
        chk("R1 train", link_train_en, 0);
        pwr_good = 1'b1;
        cycles(8);
        chk("R2 hold without refclk", cls(), 4'b1111);
        s0 = strap_cnt;
        refclk_active = 1'b1;
        while (rst_sticky && n < 1000) begin
            @(posedge clk); #1; n++;
        end
        chk("R2 release edges", n, POR_DLY + 1);
        chk("R2 class", cls(), 4'b0000);
        chk("R11 low at release", link_train_en, 0);
        edges_until_train("R11 train delay");
        cycles(2);
        chk("R9 strobe count", strap_cnt - s0, 1);
        chk("R10 no eeprom", ee_cnt, 0);
    endtask

    task automatic t_global();
        int s0 = strap_cnt;
        int e0 = ee_cnt;
        eeprom_present = 1'b1;
        @(negedge clk);
        #2 glob_rst_n = 1'b0;
        #1;
        chk("R3 async class", cls(), 4'b1111);
        chk("R3 sec", sec_bus_rst, 1);
        cycles(3);
        glob_rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R4 held one edge", cls(), 4'b1111);
        @(posedge clk); #1;
        chk("R4 released", cls(), 4'b0000);
        edges_until_train("R11 after global");
        cycles(2);
        chk("R9 global strobe", strap_cnt - s0, 1);
        chk("R10 eeprom pulse", ee_cnt - e0, 1);
    endtask

    task automatic t_link();
        int s0 = strap_cnt;
        @(negedge clk);
        link_rst_n = 1'b0;
        #1;
        chk("R5 class", cls(), 4'b0011);
        chk("R5 sec", sec_bus_rst, 1);
        chk("R5 train", link_train_en, 0);
        cycles(3);
        link_rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R5 held", cls(), 4'b0011);
        @(posedge clk); #1;
        chk("R5 released", cls(), 4'b0000);
        edges_until_train("R11 after link");
        cycles(2);
        chk("R9 link strobe", strap_cnt - s0, 1);
    endtask

    task automatic t_hot();
        int s0 = strap_cnt;
        @(negedge clk);
        hot_rst = 1'b1;
        #1;
        chk("R6 class", cls(), 4'b0001);
        chk("R6 sec", sec_bus_rst, 1);
        cycles(3);
        chk("R11 train kept in hot", link_train_en, 1);
        hot_rst = 1'b0;
        cycles(3);
        chk("R6 released", cls(), 4'b0000);
        chk("R9 no hot strobe", strap_cnt - s0, 0);
    endtask

    task automatic t_overlap();
        int s0 = strap_cnt;
        @(negedge clk);
        hot_rst = 1'b1;
        link_rst_n = 1'b0;
        glob_rst_n = 1'b0;
        #1;
        chk("R7 widest", cls(), 4'b1111);
        cycles(2);
        glob_rst_n = 1'b1;
        cycles(3);
        chk("R7 narrows to link", cls(), 4'b0011);
        link_rst_n = 1'b1;
        cycles(3);
        chk("R7 narrows to hot", cls(), 4'b0001);
        chk("R7 sec while hot", sec_bus_rst, 1);
        hot_rst = 1'b0;
        cycles(2);
        chk("R7 none", cls(), 4'b0000);
        chk("R9 one strobe", strap_cnt - s0, 1);
    endtask

    task automatic t_sw();
        @(negedge clk);
        sw_sec_rst = 1'b1;
        #1;
        chk("R8 sec on", sec_bus_rst, 1);
        chk("R8 classes untouched", cls(), 4'b0000);
        cycles(2);
        sw_sec_rst = 1'b0;
        #1;
        chk("R8 sec off", sec_bus_rst, 0);
    endtask

    task automatic t_power_drop();
        @(negedge clk);
        #2 pwr_good = 1'b0;
        #1;
        cycles(1);
        chk("R1 drop class", cls(), 4'b1111);
        chk("R1 drop train", link_train_en, 0);
    endtask

    initial begin
        t_power_on();
        t_global();
        t_link();
        cycles(TRAIN_DLY + 4);
        t_hot();
        t_overlap();
        t_sw();
        t_power_drop();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule